// File: doc/BRIEF.md
# IDE Channel Mode Timing Word Generator

This block turns the transfer modes chosen for the two drives on an IDE channel into one 32-bit timing word per drive. Each word holds tick counts for the programmed I/O strobe, the multiword DMA strobe and, on the faster controller variant, the Ultra DMA cycle. The block then decides which word goes into the channel's single timing register. Nanosecond limits for each mode are held inside the block. They are converted to clock ticks by rounding up, with a tick of 30 ns or 15 ns depending on the variant. Recovery offsets and minimum clamps are applied per variant.

Software, or a neighbouring controller, sets the per-drive enable flags, the mode numbers and the variant flag, then pulses `load`. The block captures the inputs and publishes both words, the register value and a switching flag together, with a one-cycle `done` pulse. While switching is enabled, the timing register follows the drive-select bit.

Top module: `ata_timing_calc`

## Requirements
- R1: During reset and on the first cycle after it, `word0`, `word1`, `cfg_word`, `switch_en` and `done` are all zero.
- R2: A time in ns becomes ticks as ceil(ns/30) when `fast_tick` is 0 and as ceil(ns/15) when it is 1. The cycle/active limits in ns are: programmed I/O modes 0..4 = 600/180, 390/150, 240/105, 180/90, 120/75; multiword DMA modes 0..2 = 480/240, 165/90, 120/75; Ultra DMA modes 0..4 = 120/180, 90/150, 60/120, 45/90, 30/90.
- R3: Programmed I/O on the 30 ns variant: active = max(act ticks, 1) at bit 0, recovery = max(cycle − active − 4, 1) at bit 5.
- R4: Multiword DMA on the 30 ns variant: active ticks at bit 11, recovery = max(cycle − active − 1, 1) at bit 16, and bit 21 is zero.
- R5: On the 15 ns variant, recovery is cycle − active with no offset or clamp. Programmed I/O puts active at bit 0 and recovery at bit 5. Multiword DMA puts active at bit 10 and recovery at bit 15.
- R6: On the 15 ns variant, an Ultra DMA enable adds the cycle ticks at bit 21, the active ticks at bit 25, and a 1 at bit 20. On the 30 ns variant the Ultra DMA enable has no effect on the word.
- R7: A field group is OR-ed into a drive's word only when that drive's matching enable is set. A drive with no enables gets a zero word.
- R8: On recompute, `cfg_word` takes `word0` if it is nonzero, otherwise `word1` if that is nonzero, and otherwise keeps its previous value.
- R9: On recompute, `switch_en` becomes 1 exactly when both words are nonzero and differ.
- R10: While `switch_en` is 1, a change of `drive_sel` loads the newly selected drive's word into `cfg_word` one clock later. While `switch_en` is 0, `drive_sel` has no effect on `cfg_word`.
- R11: Mode numbers above a table's range act as the highest mode: programmed I/O 4, multiword DMA 2, Ultra DMA 4.
- R12: A `load` sampled at one edge updates all outputs at the next edge, and `done` is high for exactly that one cycle. If a select change is seen on the update edge, the recompute wins and the select change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Recompute strobe; captures all mode inputs |
| fast_tick | input | 1 | 1 = 15 ns tick variant, 0 = 30 ns tick variant |
| pio_en | input | 2 | Programmed I/O enable, bit d for drive d |
| pio_mode | input | 6 | Programmed I/O mode, drive d in bits [3d+2:3d] |
| dma_en | input | 2 | Multiword DMA enable per drive |
| dma_mode | input | 4 | Multiword DMA mode, drive d in bits [2d+1:2d] |
| udma_en | input | 2 | Ultra DMA enable per drive |
| udma_mode | input | 6 | Ultra DMA mode, drive d in bits [3d+2:3d] |
| drive_sel | input | 1 | Currently selected drive |
| word0 | output | 32 | Timing word computed for drive 0 |
| word1 | output | 32 | Timing word computed for drive 1 |
| cfg_word | output | 32 | Value held in the channel timing register |
| switch_en | output | 1 | Register follows drive_sel |
| done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The recompute and a drive-select switch can both want to write `cfg_word` on the same edge. The bench provokes this by loading two differing words while `drive_sel` is 0, then flipping `drive_sel` so that the change is seen on the same edge as the update. It passes only if `cfg_word` holds drive 0's word on that cycle and on the next one, which shows that the select change was dropped and not applied late.

// File: rtl/ata_tm_pkg.sv
// Package: shared per-drive mode record, mode limit tables (ns) and the
// tick conversion. Assumes mode numbers fit in 3 bits (DMA in 2 bits).
package ata_tm_pkg;

    localparam int MODE_W     = 3;
    localparam int DMODE_W    = 2;
    localparam int WORD_W     = 32;
    localparam int SLOW_NS    = 30;
    localparam int FAST_NS    = 15;
    localparam int PIO_MAX    = 4;
    localparam int DMA_MAX    = 2;
    localparam int UDMA_MAX   = 4;

    // field positions, 30 ns variant
    localparam int S_PIO_ACT  = 0;
    localparam int S_PIO_REC  = 5;
    localparam int S_DMA_ACT  = 11;
    localparam int S_DMA_REC  = 16;
    localparam int S_DMA_HALF = 21;
    localparam int S_PIO_OFS  = 4;
    localparam int S_DMA_OFS  = 1;

    // field positions, 15 ns variant
    localparam int F_PIO_ACT  = 0;
    localparam int F_PIO_REC  = 5;
    localparam int F_DMA_ACT  = 10;
    localparam int F_DMA_REC  = 15;
    localparam int F_UDMA_EN  = 20;
    localparam int F_UDMA_CYC = 21;
    localparam int F_UDMA_ACT = 25;

    typedef struct packed {
        logic               pio_en;
        logic [MODE_W-1:0]  pio_mode;
        logic               dma_en;
        logic [DMODE_W-1:0] dma_mode;
        logic               udma_en;
        logic [MODE_W-1:0]  udma_mode;
    } drive_cfg_t;

    typedef struct packed {
        int cyc;
        int act;
    } limit_t;

    // Programmed I/O limits, saturating at the top mode
    function automatic limit_t pio_limit(logic [MODE_W-1:0] m);
        limit_t l;
        case ((int'(m) > PIO_MAX) ? PIO_MAX : int'(m))
            0:       l = '{cyc: 600, act: 180};
            1:       l = '{cyc: 390, act: 150};
            2:       l = '{cyc: 240, act: 105};
            3:       l = '{cyc: 180, act: 90};
            default: l = '{cyc: 120, act: 75};
        endcase
        return l;
    endfunction

    // Multiword DMA limits, saturating at the top mode
    function automatic limit_t dma_limit(logic [DMODE_W-1:0] m);
        limit_t l;
        case ((int'(m) > DMA_MAX) ? DMA_MAX : int'(m))
            0:       l = '{cyc: 480, act: 240};
            1:       l = '{cyc: 165, act: 90};
            default: l = '{cyc: 120, act: 75};
        endcase
        return l;
    endfunction

    // Ultra DMA limits, saturating at the top mode
    function automatic limit_t udma_limit(logic [MODE_W-1:0] m);
        limit_t l;
        case ((int'(m) > UDMA_MAX) ? UDMA_MAX : int'(m))
            0:       l = '{cyc: 120, act: 180};
            1:       l = '{cyc: 90,  act: 150};
            2:       l = '{cyc: 60,  act: 120};
            3:       l = '{cyc: 45,  act: 90};
            default: l = '{cyc: 30,  act: 90};
        endcase
        return l;
    endfunction

    // Round a nanosecond time up to whole ticks of the chosen variant
    function automatic int to_ticks(int ns, logic fast);
        int d;
        d = fast ? FAST_NS : SLOW_NS;
        return (ns + d - 1) / d;
    endfunction

endpackage

// File: rtl/ata_tm_word.sv
// Module: combinational timing word builder for one drive.
// Assumes the drive record and variant flag are already registered upstream.
module ata_tm_word
    import ata_tm_pkg::*;
(
    input  drive_cfg_t        cfg,
    input  logic              fast,
    output logic [WORD_W-1:0] word
);

    limit_t pl, dl, ul;
    int     p_cyc, p_act, p_rec;
    int     d_cyc, d_act, d_rec;
    int     u_cyc, u_act;

    // Build the word from enabled field groups, per-variant rules
    always_comb begin
        pl    = pio_limit(cfg.pio_mode);
        dl    = dma_limit(cfg.dma_mode);
        ul    = udma_limit(cfg.udma_mode);
        p_cyc = to_ticks(pl.cyc, fast);
        p_act = to_ticks(pl.act, fast);
        d_cyc = to_ticks(dl.cyc, fast);
        d_act = to_ticks(dl.act, fast);
        u_cyc = to_ticks(ul.cyc, fast);
        u_act = to_ticks(ul.act, fast);
        p_rec = 0;
        d_rec = 0;
        word  = '0;
        if (fast) begin
            p_rec = p_cyc - p_act;
            d_rec = d_cyc - d_act;
            if (cfg.pio_en)
                word = word | WORD_W'((p_rec << F_PIO_REC) | (p_act << F_PIO_ACT));
            if (cfg.dma_en)
                word = word | WORD_W'((d_rec << F_DMA_REC) | (d_act << F_DMA_ACT));
            if (cfg.udma_en)
                word = word | WORD_W'((u_act << F_UDMA_ACT) | (u_cyc << F_UDMA_CYC)
                                      | (1 << F_UDMA_EN));
        end else begin
            if (p_act < 1) p_act = 1;
            p_rec = p_cyc - p_act - S_PIO_OFS;
            if (p_rec < 1) p_rec = 1;
            d_rec = d_cyc - d_act - S_DMA_OFS;
            if (d_rec < 1) d_rec = 1;
            if (cfg.pio_en)
                word = word | WORD_W'((p_rec << S_PIO_REC) | (p_act << S_PIO_ACT));
            if (cfg.dma_en)
                word = word | WORD_W'((0 << S_DMA_HALF) | (d_rec << S_DMA_REC)
                                      | (d_act << S_DMA_ACT));
        end
    end

endmodule

// File: rtl/ata_tm_regsel.sv
// Module: output registers and timing register selection policy.
// Assumes upd is a one-cycle request carrying freshly computed words.
module ata_tm_regsel
    import ata_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [WORD_W-1:0] w0_in,
    input  logic [WORD_W-1:0] w1_in,
    input  logic              drive_sel,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] cfg_word,
    output logic              switch_en,
    output logic              done
);

    logic sel_q;
    logic nz0, nz1;

    // Nonzero flags of the incoming words
    always_comb begin
        nz0 = (w0_in != '0);
        nz1 = (w1_in != '0);
    end

    // Publish words; recompute has priority over a select switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0     <= '0;
            word1     <= '0;
            cfg_word  <= '0;
            switch_en <= 1'b0;
            done      <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            sel_q <= drive_sel;
            done  <= upd;
            if (upd) begin
                word0     <= w0_in;
                word1     <= w1_in;
                switch_en <= nz0 && nz1 && (w0_in != w1_in);
                if (nz0)
                    cfg_word <= w0_in;
                else if (nz1)
                    cfg_word <= w1_in;
            end else if (switch_en && (drive_sel != sel_q)) begin
                cfg_word <= drive_sel ? word1 : word0;
            end
        end
    end

endmodule

// File: rtl/ata_timing_calc.sv
// Module: top of the timing word generator. Captures mode inputs on load,
// builds one word per drive and hands them to the register selector.
// Assumes two drives per channel; mode buses are packed per drive.
module ata_timing_calc
    import ata_tm_pkg::*;
#(
    parameter int NDRV = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    fast_tick,
    input  logic [NDRV-1:0]         pio_en,
    input  logic [NDRV*MODE_W-1:0]  pio_mode,
    input  logic [NDRV-1:0]         dma_en,
    input  logic [NDRV*DMODE_W-1:0] dma_mode,
    input  logic [NDRV-1:0]         udma_en,
    input  logic [NDRV*MODE_W-1:0]  udma_mode,
    input  logic                    drive_sel,
    output logic [WORD_W-1:0]       word0,
    output logic [WORD_W-1:0]       word1,
    output logic [WORD_W-1:0]       cfg_word,
    output logic                    switch_en,
    output logic                    done
);

    drive_cfg_t        cap  [NDRV];
    logic [WORD_W-1:0] wcalc[NDRV];
    logic              fast_q;
    logic              upd_q;

    // Capture the mode inputs and variant flag on a load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            upd_q  <= 1'b0;
            for (int d = 0; d < NDRV; d++) cap[d] <= '0;
        end else begin
            upd_q <= load;
            if (load) begin
                fast_q <= fast_tick;
                for (int d = 0; d < NDRV; d++) begin
                    cap[d].pio_en    <= pio_en[d];
                    cap[d].pio_mode  <= pio_mode[d*MODE_W +: MODE_W];
                    cap[d].dma_en    <= dma_en[d];
                    cap[d].dma_mode  <= dma_mode[d*DMODE_W +: DMODE_W];
                    cap[d].udma_en   <= udma_en[d];
                    cap[d].udma_mode <= udma_mode[d*MODE_W +: MODE_W];
                end
            end
        end
    end

    for (genvar g = 0; g < NDRV; g++) begin : g_drv
        ata_tm_word u_word (
            .cfg  (cap[g]),
            .fast (fast_q),
            .word (wcalc[g])
        );
    end

    ata_tm_regsel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd_q),
        .w0_in     (wcalc[0]),
        .w1_in     (wcalc[1]),
        .drive_sel (drive_sel),
        .word0     (word0),
        .word1     (word1),
        .cfg_word  (cfg_word),
        .switch_en (switch_en),
        .done      (done)
    );

endmodule

// File: rtl/ata_timing_calc_chk.sv
// Checker: temporal properties of the timing word generator, bound to the top.
module ata_timing_calc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic        fast_tick,
    input logic        drive_sel,
    input logic [31:0] word0,
    input logic [31:0] word1,
    input logic [31:0] cfg_word,
    input logic        switch_en,
    input logic        done
);

    a_r12_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(load, 2));

    a_r9_switch_needs_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        switch_en |-> (word0 != 32'd0 && word1 != 32'd0 && word0 != word1));

    a_r10_cfg_from_words: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && !done) |-> (cfg_word == word0 || cfg_word == word1));

    a_r6_slow_no_udma: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(fast_tick, 2)) |-> (!word0[20] && !word1[20]));

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(switch_en)) |-> $stable(cfg_word));

endmodule

bind ata_timing_calc ata_timing_calc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .fast_tick (fast_tick),
    .drive_sel (drive_sel),
    .word0     (word0),
    .word1     (word1),
    .cfg_word  (cfg_word),
    .switch_en (switch_en),
    .done      (done)
);

// File: tb/ata_timing_calc_bench.sv
// Bench: directed scenarios for the timing word generator, one task each.
module ata_timing_calc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        fast_tick = 1'b0;
    logic [1:0]  pio_en = '0, dma_en = '0, udma_en = '0;
    logic [5:0]  pio_mode = '0, udma_mode = '0;
    logic [3:0]  dma_mode = '0;
    logic        drive_sel = 1'b0;
    logic [31:0] word0, word1, cfg_word;
    logic        switch_en, done;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    ata_timing_calc u_ata_timing_calc (
        .clk(clk), .rst_n(rst_n), .load(load), .fast_tick(fast_tick),
        .pio_en(pio_en), .pio_mode(pio_mode), .dma_en(dma_en),
        .dma_mode(dma_mode), .udma_en(udma_en), .udma_mode(udma_mode),
        .drive_sel(drive_sel), .word0(word0), .word1(word1),
        .cfg_word(cfg_word), .switch_en(switch_en), .done(done)
    );

    // ---- reference model built from the requirements ----
    function automatic int tk(int ns, bit f);
        int d = f ? 15 : 30;
        return (ns + d - 1) / d;
    endfunction

    function automatic logic [31:0] model(bit f, bit pe, int pm, bit de, int dm,
                                          bit ue, int um);
        int pc[5] = '{600, 390, 240, 180, 120};
        int pa[5] = '{180, 150, 105, 90, 75};
        int dc[3] = '{480, 165, 120};
        int da[3] = '{240, 90, 75};
        int uc[5] = '{120, 90, 60, 45, 30};
        int ua[5] = '{180, 150, 120, 90, 90};
        int c, a, r;
        logic [31:0] w = 0;
        if (pm > 4) pm = 4;
        if (dm > 2) dm = 2;
        if (um > 4) um = 4;
        if (pe) begin
            c = tk(pc[pm], f); a = tk(pa[pm], f);
            if (f) r = c - a;
            else begin
                if (a < 1) a = 1;
                r = c - a - 4; if (r < 1) r = 1;
            end
            w |= 32'(a) | (32'(r) << 5);
        end
        if (de) begin
            c = tk(dc[dm], f); a = tk(da[dm], f);
            if (f) begin r = c - a; w |= (32'(a) << 10) | (32'(r) << 15); end
            else begin
                r = c - a - 1; if (r < 1) r = 1;
                w |= (32'(a) << 11) | (32'(r) << 16);
            end
        end
        if (ue && f)
            w |= (32'(tk(uc[um], f)) << 21) | (32'(tk(ua[um], f)) << 25) | 32'h0010_0000;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Set drive d's inputs
    task automatic set_drv(int d, bit pe, int pm, bit de, int dm, bit ue, int um);
        pio_en[d] = pe;  pio_mode[d*3 +: 3]  = 3'(pm);
        dma_en[d] = de;  dma_mode[d*2 +: 2]  = 2'(dm);
        udma_en[d] = ue; udma_mode[d*3 +: 3] = 3'(um);
    endtask

    // Pulse load, then check done for exactly one cycle (R12)
    task automatic do_load();
        @(negedge clk) load = 1'b1;
        @(negedge clk) load = 1'b0;
        @(negedge clk);
        chk("R12 done pulse", 32'(done), 32'd1);
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 word0", word0, 0);
        chk("R1 cfg", cfg_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word1 after", word1, 0);
        chk("R1 flags after", {30'd0, switch_en, done}, 0);
    endtask

    task automatic t_slow_pio();
        fast_tick = 0;
        set_drv(0, 1, 0, 0, 0, 0, 0);
        set_drv(1, 1, 4, 0, 0, 0, 0);
        do_load();
        chk("R3 slow pio mode0", word0, model(0, 1, 0, 0, 0, 0, 0));
        chk("R3 slow pio mode4 clamp", word1, model(0, 1, 4, 0, 0, 0, 0));
        chk("R2 slow pio mode0 literal", word0, 32'h146);
        chk("R8 cfg takes word0", cfg_word, word0);
        chk("R9 switch on", 32'(switch_en), 1);
    endtask

    task automatic t_slow_dma();
        fast_tick = 0;
        set_drv(0, 1, 2, 1, 0, 1, 3);
        set_drv(1, 0, 0, 1, 2, 0, 0);
        do_load();
        chk("R4 slow dma mode0 + R6 udma ignored", word0, model(0, 1, 2, 1, 0, 0, 0));
        chk("R4 slow dma mode2 clamp", word1, model(0, 0, 0, 1, 2, 0, 0));
    endtask

    task automatic t_fast_all();
        fast_tick = 1;
        set_drv(0, 1, 4, 1, 2, 1, 4);
        set_drv(1, 1, 0, 1, 0, 1, 0);
        do_load();
        chk("R5 R6 fast full drive0", word0, model(1, 1, 4, 1, 2, 1, 4));
        chk("R5 R6 fast full drive1", word1, model(1, 1, 0, 1, 0, 1, 0));
        chk("R6 udma enable bit", 32'(word0[20]), 1);
    endtask

    task automatic t_saturate();
        fast_tick = 1;
        set_drv(0, 1, 7, 1, 3, 1, 6);
        set_drv(1, 1, 5, 0, 0, 1, 5);
        do_load();
        chk("R11 saturate drive0", word0, model(1, 1, 4, 1, 2, 1, 4));
        chk("R11 saturate drive1", word1, model(1, 1, 4, 0, 0, 1, 4));
    endtask

    task automatic t_only_drive1();
        fast_tick = 0;
        set_drv(0, 0, 0, 0, 0, 0, 0);
        set_drv(1, 1, 3, 0, 0, 0, 0);
        do_load();
        chk("R7 zero word", word0, 0);
        chk("R8 cfg takes word1", cfg_word, model(0, 1, 3, 0, 0, 0, 0));
        chk("R9 no switch single", 32'(switch_en), 0);
        @(negedge clk) drive_sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 select ignored", cfg_word, model(0, 1, 3, 0, 0, 0, 0));
        @(negedge clk) drive_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_equal();
        fast_tick = 1;
        set_drv(0, 1, 2, 0, 0, 0, 0);
        set_drv(1, 1, 2, 0, 0, 0, 0);
        do_load();
        chk("R9 equal words no switch", 32'(switch_en), 0);
        chk("R8 equal cfg", cfg_word, model(1, 1, 2, 0, 0, 0, 0));
    endtask

    task automatic t_both_zero();
        logic [31:0] prev = cfg_word;
        set_drv(0, 0, 0, 0, 0, 0, 0);
        set_drv(1, 0, 0, 0, 0, 0, 0);
        do_load();
        chk("R8 both zero keeps cfg", cfg_word, prev);
        chk("R7 both zero words", word0 | word1, 0);
    endtask

    task automatic t_select();
        logic [31:0] e0, e1;
        fast_tick = 1;
        set_drv(0, 1, 1, 0, 0, 0, 0);
        set_drv(1, 0, 0, 1, 1, 0, 0);
        e0 = model(1, 1, 1, 0, 0, 0, 0);
        e1 = model(1, 0, 0, 1, 1, 0, 0);
        do_load();
        chk("R10 start on drive0", cfg_word, e0);
        @(negedge clk) drive_sel = 1'b1;
        chk("R10 not before edge", cfg_word, e0);
        @(negedge clk);
        chk("R10 follows drive1", cfg_word, e1);
        @(negedge clk) drive_sel = 1'b0;
        @(negedge clk);
        chk("R10 follows drive0", cfg_word, e0);
    endtask

    task automatic t_collide();
        logic [31:0] e0;
        fast_tick = 0;
        drive_sel = 1'b0;
        set_drv(0, 1, 0, 1, 1, 0, 0);
        set_drv(1, 1, 3, 0, 0, 0, 0);
        e0 = model(0, 1, 0, 1, 1, 0, 0);
        @(negedge clk) load = 1'b1;
        @(negedge clk) begin load = 1'b0; drive_sel = 1'b1; end
        @(negedge clk);
        chk("R12 collide done", 32'(done), 1);
        chk("R12 recompute wins", cfg_word, e0);
        @(negedge clk);
        chk("R12 select dropped", cfg_word, e0);
        chk("R9 collide switch on", 32'(switch_en), 1);
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_slow_pio();
        t_slow_dma();
        t_fast_all();
        t_saturate();
        t_only_drive1();
        t_equal();
        t_both_zero();
        t_select();
        t_collide();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule